// File: doc/BRIEF.md
# Queued Memory-to-Device DMA Engine

This block is a small DMA engine driven through a word-indexed register window. Software programs a source address, a destination address and two lengths counted in 32-bit words. Writing the destination length turns the four values into a command and pushes it into a short in-order command queue. The engine takes the command at the queue head and walks the source in bursts, each one a single read request on a simple request/acknowledge memory port.

When the loopback control bit is set, every burst that was read is written back to the destination as a matching write request. In that case the burst is also limited by what remains of the destination. Completion and queue-overflow events are kept in write-1-to-clear status bits. A mask register selects which of them drive the single interrupt output.

The memory port carries requests only: address, byte count and direction. Data movement and the bus fabric belong to the neighbour that answers the request.

Top module: `dmaq_engine`

## Requirements
- R1: After reset the queue-status register (index 6) reads 0x4000_0000 (queue-empty at bit 30 set, queue-full at bit 31 clear), the mask register (index 5) reads all ones, the interrupt-status register (index 4) reads zero, and `irq` and `mem_req` are low.
- R2: A write to index 3 (destination length) enqueues a command. The command takes the addresses at indices 0 and 1 with bits 1:0 forced to zero, and the source length at index 2 and the written destination length, each multiplied by 4 to give bytes. Every request address therefore has bits 1:0 clear.
- R3: Each length register (indices 2 and 3) stores only bits 26:0. Bits 31:27 always read zero.
- R4: Each read request asks for the smaller of 1024 bytes and the remaining source bytes. After an acknowledged read, the next read address is higher by the burst size.
- R5: With loopback on (bit 4 of index 7), each burst is also capped by the remaining destination bytes. Each acknowledged read is followed by one write request (`mem_we` high) to the current destination address with the same byte count. The destination then advances by that count.
- R6: With loopback off, no write request is issued, and the destination length neither caps nor extends the transfer.
- R7: A request keeps `mem_addr`, `mem_len` and `mem_we` unchanged and `mem_req` high until the cycle in which `mem_ack` is high. Only one request is outstanding at a time.
- R8: A command retires when its next burst would be zero bytes: the source is exhausted, or in loopback either side is exhausted. A zero-length command retires without any memory request. Retiring sets interrupt-status bits 13 (done) and 12 (partial done) and pops the queue head. Commands run in the order they were written.
- R9: The queue holds 4 commands, and queue-full (bit 31 of index 6) reads 1 while 4 are pending. A command stays pending until it retires. A destination-length write while the queue is full is dropped and sets interrupt-status bit 14 (overflow).
- R10: `irq` is high exactly when some interrupt-status bit is set whose mask bit is 0. Writing 1 to a status bit clears it, and a new event in the same cycle wins over the clear.
- R11: In the misc-control register (index 7), only bit 4 (loopback) is writable. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_idx | input | 3 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_idx` (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request direction: 1 write, 0 read |
| mem_addr | output | 32 | Request byte address, word aligned |
| mem_len | output | 11 | Request byte count, 4 to 1024 |
| mem_ack | input | 1 | Memory accepts the request in this cycle |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume the memory side raises `mem_ack` only while `mem_req` is high. They also assume that a held request is released only by that acknowledge, so an acknowledge never refers to a request that has not yet appeared. The bench responder meets both assumptions. It acknowledges only after seeing a request on two earlier falling edges, drops the acknowledge after one cycle, and can withhold acknowledges entirely to keep commands queued. Register writes arrive one per cycle with no read side effects, which is what the status and overflow properties rely on.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

   typedef enum logic [1:0] {
      MV_IDLE  = 2'd0,
      MV_STEP  = 2'd1,
      MV_READ  = 2'd2,
      MV_WRITE = 2'd3
   } mv_state_e;

   // register word indices
   localparam int unsigned RI_SRC_ADDR = 0;
   localparam int unsigned RI_DST_ADDR = 1;
   localparam int unsigned RI_SRC_LEN  = 2;
   localparam int unsigned RI_DST_LEN  = 3;
   localparam int unsigned RI_INT_STS  = 4;
   localparam int unsigned RI_INT_MASK = 5;
   localparam int unsigned RI_QSTAT    = 6;
   localparam int unsigned RI_MISC     = 7;

   // bit positions
   localparam int unsigned IB_PART_DONE = 12;
   localparam int unsigned IB_DONE      = 13;
   localparam int unsigned IB_Q_OVF     = 14;
   localparam int unsigned QB_FULL      = 31;
   localparam int unsigned QB_EMPTY     = 30;
   localparam int unsigned MB_LOOP      = 4;

   localparam int unsigned REG_W = 32;

endpackage

// File: rtl/dmaq_cmd_fifo.sv
module dmaq_cmd_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("dmaq_cmd_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         logic         valid_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q  <= '0;
               valid_q <= 1'b0;
            end else if (push && !valid_q) begin
               slot_q  <= din;
               valid_q <= 1'b1;
            end else if (pop && valid_q) begin
               valid_q <= 1'b0;
            end
         end

         assign dout  = slot_q;
         assign full  = valid_q;
         assign empty = !valid_q;
      end else begin : g_ring
         localparam int unsigned PW = $clog2(DEPTH);
         localparam int unsigned CW = $clog2(DEPTH + 1);

         logic [W-1:0]  slot_q [DEPTH];
         logic [PW-1:0] rd_q, wr_q;
         logic [CW-1:0] cnt_q;
         logic          do_push, do_pop;

         assign full    = (cnt_q == CW'(DEPTH));
         assign empty   = (cnt_q == '0);
         assign do_push = push && !full;
         assign do_pop  = pop && !empty;
         assign dout    = slot_q[rd_q];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
               for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
            end else begin
               if (do_push) begin
                  slot_q[wr_q] <= din;
                  wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
               end
               if (do_pop) begin
                  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
               end
               cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dmaq_regs.sv
module dmaq_regs
   import dmaq_pkg::*;
#(
   parameter int unsigned AW  = 32,
   parameter int unsigned LW  = 27,
   parameter int unsigned RIW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [RIW-1:0]   idx,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic             q_full,
   input  logic             q_empty,
   input  logic             retire,
   output logic             push,
   output logic [AW-1:0]    src_addr,
   output logic [AW-1:0]    dst_addr,
   output logic [LW-1:0]    src_len,
   output logic [LW-1:0]    dst_len_new,
   output logic             loop_en,
   output logic             irq
);

   logic [AW-1:0]    src_addr_q, dst_addr_q;
   logic [LW-1:0]    src_len_q, dst_len_q;
   logic [REG_W-1:0] mask_q;
   logic             ovf_q, done_q, pdone_q, loop_q;
   logic [REG_W-1:0] sts_vec, q_vec;
   logic             sel_sts, ovf_set;

   assign push    = wr && (idx == RIW'(RI_DST_LEN));
   assign sel_sts = wr && (idx == RIW'(RI_INT_STS));
   assign ovf_set = push && q_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_addr_q <= '0;
         dst_addr_q <= '0;
         src_len_q  <= '0;
         dst_len_q  <= '0;
         mask_q     <= '1;
         loop_q     <= 1'b0;
      end else if (wr) begin
         case (int'(idx))
            RI_SRC_ADDR: src_addr_q <= wdata[AW-1:0];
            RI_DST_ADDR: dst_addr_q <= wdata[AW-1:0];
            RI_SRC_LEN:  src_len_q  <= wdata[LW-1:0];
            RI_DST_LEN:  dst_len_q  <= wdata[LW-1:0];
            RI_INT_MASK: mask_q     <= wdata;
            RI_MISC:     loop_q     <= wdata[MB_LOOP];
            default: ;
         endcase
      end
   end

   // sticky status: a new event wins over a same-cycle write-1 clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q   <= 1'b0;
         done_q  <= 1'b0;
         pdone_q <= 1'b0;
      end else begin
         ovf_q   <= ovf_set || (ovf_q   && !(sel_sts && wdata[IB_Q_OVF]));
         done_q  <= retire  || (done_q  && !(sel_sts && wdata[IB_DONE]));
         pdone_q <= retire  || (pdone_q && !(sel_sts && wdata[IB_PART_DONE]));
      end
   end

   always_comb begin
      sts_vec = '0;
      sts_vec[IB_Q_OVF]     = ovf_q;
      sts_vec[IB_DONE]      = done_q;
      sts_vec[IB_PART_DONE] = pdone_q;
      q_vec = '0;
      q_vec[QB_FULL]  = q_full;
      q_vec[QB_EMPTY] = q_empty;
   end

   always_comb begin
      rdata = '0;
      case (int'(idx))
         RI_SRC_ADDR: rdata = REG_W'(src_addr_q);
         RI_DST_ADDR: rdata = REG_W'(dst_addr_q);
         RI_SRC_LEN:  rdata = REG_W'(src_len_q);
         RI_DST_LEN:  rdata = REG_W'(dst_len_q);
         RI_INT_STS:  rdata = sts_vec;
         RI_INT_MASK: rdata = mask_q;
         RI_QSTAT:    rdata = q_vec;
         RI_MISC:     rdata[MB_LOOP] = loop_q;
         default:     rdata = '0;
      endcase
   end

   assign src_addr    = src_addr_q;
   assign dst_addr    = dst_addr_q;
   assign src_len     = src_len_q;
   assign dst_len_new = wdata[LW-1:0];
   assign loop_en     = loop_q;
   assign irq         = |(sts_vec & ~mask_q);

endmodule

// File: rtl/dmaq_mover.sv
module dmaq_mover
   import dmaq_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned BLW       = 29,
   parameter int unsigned BURST_MAX = 1024,
   parameter int unsigned BW        = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           q_empty,
   input  logic [AW-1:0]  h_src,
   input  logic [AW-1:0]  h_dst,
   input  logic [BLW-1:0] h_slen,
   input  logic [BLW-1:0] h_dlen,
   input  logic           loop_en,
   output logic           retire,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [BW-1:0]  mem_len,
   input  logic           mem_ack
);

   mv_state_e      st_q;
   logic [AW-1:0]  src_q, dst_q;
   logic [BLW-1:0] rsrc_q, rdst_q;
   logic [BW-1:0]  burst_q;
   logic           lb_q;
   logic [BLW-1:0] src_cap, both_cap;

   generate
      if (BURST_MAX < (64'd1 << BLW)) begin : g_cap
         localparam logic [BLW-1:0] CAP_L = BLW'(BURST_MAX);
         assign src_cap = (rsrc_q > CAP_L) ? CAP_L : rsrc_q;
      end else begin : g_nocap
         assign src_cap = rsrc_q;
      end
   endgenerate

   assign both_cap = (loop_en && (rdst_q < src_cap)) ? rdst_q : src_cap;
   assign retire   = (st_q == MV_STEP) && (both_cap == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= MV_IDLE;
         src_q   <= '0;
         dst_q   <= '0;
         rsrc_q  <= '0;
         rdst_q  <= '0;
         burst_q <= '0;
         lb_q    <= 1'b0;
      end else begin
         case (st_q)
            MV_IDLE: if (!q_empty) begin
               src_q  <= h_src;
               dst_q  <= h_dst;
               rsrc_q <= h_slen;
               rdst_q <= h_dlen;
               st_q   <= MV_STEP;
            end
            MV_STEP: if (both_cap == '0) begin
               st_q <= MV_IDLE;
            end else begin
               burst_q <= both_cap[BW-1:0];
               lb_q    <= loop_en;
               st_q    <= MV_READ;
            end
            MV_READ: if (mem_ack) begin
               src_q  <= src_q + AW'(burst_q);
               rsrc_q <= rsrc_q - BLW'(burst_q);
               st_q   <= lb_q ? MV_WRITE : MV_STEP;
            end
            MV_WRITE: if (mem_ack) begin
               dst_q  <= dst_q + AW'(burst_q);
               rdst_q <= rdst_q - BLW'(burst_q);
               st_q   <= MV_STEP;
            end
            default: st_q <= MV_IDLE;
         endcase
      end
   end

   assign mem_req  = (st_q == MV_READ) || (st_q == MV_WRITE);
   assign mem_we   = (st_q == MV_WRITE);
   assign mem_addr = mem_we ? dst_q : src_q;
   assign mem_len  = burst_q;

endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
   import dmaq_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned LW        = 27,
   parameter int unsigned QDEPTH    = 4,
   parameter int unsigned BURST_MAX = 1024,
   parameter int unsigned RIW       = 3,
   localparam int unsigned BLW      = LW + 2,
   localparam int unsigned BW       = $clog2(BURST_MAX) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [RIW-1:0]   reg_idx,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [BW-1:0]    mem_len,
   input  logic             mem_ack,
   output logic             irq
);

   localparam int unsigned CMD_W = 2 * AW + 2 * BLW;

   generate
      if (AW > REG_W || AW < BW) begin : g_bad_aw
         $error("dmaq_engine: AW must lie between BW and 32");
      end
      if (LW + 2 > REG_W + 1 || BLW < BW) begin : g_bad_lw
         $error("dmaq_engine: LW out of range");
      end
      if (BURST_MAX < 4 || (BURST_MAX & (BURST_MAX - 1)) != 0) begin : g_bad_burst
         $error("dmaq_engine: BURST_MAX must be a power of two of at least 4");
      end
      if ((1 << RIW) < RI_MISC + 1) begin : g_bad_riw
         $error("dmaq_engine: RIW too narrow for the register window");
      end
   endgenerate

   logic             push_req, q_full, q_empty, retire, loop_en;
   logic [AW-1:0]    r_src, r_dst, h_src, h_dst;
   logic [LW-1:0]    r_slen, r_dlen;
   logic [BLW-1:0]   h_slen, h_dlen;
   logic [CMD_W-1:0] cmd_in, cmd_head;

   dmaq_regs #(.AW(AW), .LW(LW), .RIW(RIW)) u_regs (
      .clk, .rst_n,
      .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata),
      .q_full, .q_empty, .retire,
      .push(push_req), .src_addr(r_src), .dst_addr(r_dst),
      .src_len(r_slen), .dst_len_new(r_dlen), .loop_en, .irq
   );

   // command: aligned addresses, byte lengths
   assign cmd_in = {r_src & ~AW'(3), r_dst & ~AW'(3), {r_slen, 2'b00}, {r_dlen, 2'b00}};

   dmaq_cmd_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) u_queue (
      .clk, .rst_n,
      .push(push_req && !q_full), .pop(retire),
      .din(cmd_in), .dout(cmd_head), .full(q_full), .empty(q_empty)
   );

   assign {h_src, h_dst, h_slen, h_dlen} = cmd_head;

   dmaq_mover #(.AW(AW), .BLW(BLW), .BURST_MAX(BURST_MAX), .BW(BW)) u_mover (
      .clk, .rst_n, .q_empty,
      .h_src, .h_dst, .h_slen, .h_dlen, .loop_en, .retire,
      .mem_req, .mem_we, .mem_addr, .mem_len, .mem_ack
   );

endmodule

// File: rtl/dmaq_checker.sv
module dmaq_checker #(
   parameter int unsigned AW        = 32,
   parameter int unsigned BW        = 11,
   parameter int unsigned BURST_MAX = 1024
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [BW-1:0] mem_len,
   input logic          q_full,
   input logic          q_empty
);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_we))); // R7

   AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_len != '0 && mem_len <= BW'(BURST_MAX) && mem_len[1:0] == 2'b00)); // R4

   AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !$past(mem_req && mem_we)) |-> $past(mem_req && mem_ack && !mem_we)); // R5

   AST_Q_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_full && q_empty)); // R9

endmodule

bind dmaq_engine dmaq_checker #(.AW(AW), .BW(BW), .BURST_MAX(BURST_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
   .mem_addr(mem_addr), .mem_len(mem_len), .q_full(q_full), .q_empty(q_empty)
);

// File: tb/dmaq_engine_test.sv
module dmaq_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ack, irq;
   logic [31:0] mem_addr;
   logic [10:0] mem_len;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dmaq_engine uut (
      .clk, .rst_n, .reg_wr, .reg_idx, .reg_wdata, .reg_rdata,
      .mem_req, .mem_we, .mem_addr, .mem_len, .mem_ack, .irq
   );

   // request log filled by the memory responder
   logic [31:0] log_addr [16];
   int          log_len  [16];
   logic        log_we   [16];
   int          n_log = 0;
   bit          hold_mem = 0;
   int          unstable = 0;

   initial begin
      int          wcnt;
      logic [31:0] h_addr;
      logic [10:0] h_len;
      logic        h_we;
      wcnt = 0;
      mem_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
         end else if (mem_req && !hold_mem) begin
            if (wcnt > 0 && (mem_addr !== h_addr || mem_len !== h_len || mem_we !== h_we))
               unstable++;
            h_addr = mem_addr; h_len = mem_len; h_we = mem_we;
            wcnt++;
            if (wcnt == 3) begin
               if (n_log < 16) begin
                  log_addr[n_log] = mem_addr;
                  log_len[n_log]  = int'(mem_len);
                  log_we[n_log]   = mem_we;
               end
               n_log++;
               mem_ack = 1'b1;
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input int idx, input logic [31:0] val);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = 3'(idx); reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input int idx, output logic [31:0] val);
      @(negedge clk);
      reg_idx = 3'(idx);
      #1 val = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      for (int i = 0; i < 5000; i++) begin
         reg_read(6, d);
         if (d[30]) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic push_cmd(input logic [31:0] sa, input logic [31:0] da,
                           input logic [31:0] sl, input logic [31:0] dl);
      reg_write(0, sa);
      reg_write(1, da);
      reg_write(2, sl);
      reg_write(3, dl);
   endtask

   task automatic exp_req(input string req, input int k, input logic we,
                          input logic [31:0] a, input int len);
      chk({req, " addr"}, log_addr[k], a);
      chk({req, " len"}, 32'(log_len[k]), 32'(len));
      chk({req, " dir"}, 32'(log_we[k]), 32'(we));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_read(6, d); chk("R1 queue status", d, 32'h4000_0000);
      reg_read(5, d); chk("R1 mask", d, 32'hFFFF_FFFF);
      reg_read(4, d); chk("R1 int status", d, 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 mem_req", 32'(mem_req), 32'h0);
   endtask

   task automatic t_fields();
      logic [31:0] d;
      reg_write(2, 32'hFFFF_FFFF);
      reg_read(2, d); chk("R3 source length width", d, 32'h07FF_FFFF);
      reg_write(7, 32'hFFFF_FFFF);
      reg_read(7, d); chk("R11 misc writable bits", d, 32'h0000_0010);
      reg_write(7, 32'h0);
      reg_read(7, d); chk("R11 misc cleared", d, 32'h0);
   endtask

   task automatic t_single();
      logic [31:0] d;
      n_log = 0;
      push_cmd(32'h0000_1003, 32'h0000_2002, 32'd3, 32'd100);
      wait_idle();
      chk("R6 request count", 32'(n_log), 32'd1);
      exp_req("R2 aligned, bytes = words*4", 0, 1'b0, 32'h0000_1000, 12);
      reg_read(4, d); chk("R8 done bits", d, 32'h0000_3000);
      chk("R10 masked irq low", 32'(irq), 32'h0);
   endtask

   task automatic t_bursts();
      n_log = 0;
      reg_write(4, 32'hFFFF_FFFF);
      push_cmd(32'h0000_4000, 32'h0, 32'd600, 32'd0);
      wait_idle();
      chk("R4 request count", 32'(n_log), 32'd3);
      exp_req("R4 burst 1", 0, 1'b0, 32'h0000_4000, 1024);
      exp_req("R4 burst 2", 1, 1'b0, 32'h0000_4400, 1024);
      exp_req("R4 burst 3", 2, 1'b0, 32'h0000_4800, 352);
   endtask

   task automatic t_loopback();
      n_log = 0;
      reg_write(7, 32'h10);
      push_cmd(32'h0000_8000, 32'h0000_A000, 32'd300, 32'd260);
      wait_idle();
      chk("R5 request count", 32'(n_log), 32'd4);
      exp_req("R5 read 1",  0, 1'b0, 32'h0000_8000, 1024);
      exp_req("R5 write 1", 1, 1'b1, 32'h0000_A000, 1024);
      exp_req("R5 read 2 capped by destination",  2, 1'b0, 32'h0000_8400, 16);
      exp_req("R5 write 2", 3, 1'b1, 32'h0000_A400, 16);
      reg_write(7, 32'h0);
   endtask

   task automatic t_queue();
      logic [31:0] d;
      n_log = 0;
      reg_write(4, 32'hFFFF_FFFF);
      hold_mem = 1;
      for (int i = 1; i <= 4; i++) push_cmd(32'(i * 256), 32'h0, 32'd1, 32'd0);
      reg_read(6, d); chk("R9 queue full", d, 32'h8000_0000);
      push_cmd(32'h0000_0500, 32'h0, 32'd1, 32'd0);
      reg_read(4, d); chk("R9 overflow bit", d, 32'h0000_4000);
      chk("R10 irq masked", 32'(irq), 32'h0);
      reg_write(5, ~(32'h1 << 14));
      #1 chk("R10 irq unmasked", 32'(irq), 32'h1);
      reg_write(4, 32'h0000_4000);
      reg_read(4, d); chk("R10 write-1 clear", d, 32'h0);
      chk("R10 irq after clear", 32'(irq), 32'h0);
      reg_write(5, 32'hFFFF_FFFF);
      hold_mem = 0;
      wait_idle();
      chk("R9 dropped command absent", 32'(n_log), 32'd4);
      for (int i = 0; i < 4; i++)
         exp_req("R8 in-order service", i, 1'b0, 32'((i + 1) * 256), 4);
   endtask

   task automatic t_zero();
      logic [31:0] d;
      n_log = 0;
      reg_write(4, 32'hFFFF_FFFF);
      push_cmd(32'h0000_C000, 32'h0000_D000, 32'd0, 32'd0);
      wait_idle();
      chk("R8 zero length no request", 32'(n_log), 32'd0);
      reg_read(4, d); chk("R8 zero length done", d, 32'h0000_3000);
      chk("R7 request stability", 32'(unstable), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_single();
      t_bursts();
      t_loopback();
      t_queue();
      t_zero();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule